// File: doc/BRIEF.md
# Dual Wrapping Buffer Access Port

This block is a serial slave that gives a host read and write access to two separate byte buffers of 1056 entries each. The host lowers chip select and shifts in a one-byte command. It then sends three address bytes and, for reads only, one filler byte. After that it clocks data bytes in or out for as long as it likes. A byte pointer advances after every byte. When the pointer passes the last entry it returns to entry 0, so a stream that runs long folds back over the start of the same buffer.

The serial pins are sampled in the system clock domain through two-stage synchronizers, so the serial clock must be several times slower than `clk`. Inbound bits are taken on the rising serial clock edge. Outbound bits change after the falling edge, most significant bit first. The output enable stands for the tri-state control of the data-out pin.

Top module: `dual_wrap_buf_port`

## Requirements
- R1: Command 0x54 or 0xD4 reads buffer A, and command 0x56 or 0xD6 reads buffer B.
- R2: Command 0x84 writes buffer A and command 0x87 writes buffer B. Any other command byte writes nothing and never enables the output until chip select is raised.
- R3: The 24 address bits follow the command, most significant first. The upper 13 bits are ignored and the low 11 bits give the start entry.
- R4: A read consumes one filler byte after the address. Data then leaves on `sdo`, most significant bit first, and each bit is valid at the rising serial clock edge. A write stores the bytes that follow the last address byte directly, with no filler.
- R5: After each full byte, read or written, the pointer advances. From entry 1055 it moves to entry 0.
- R6: While chip select is high, or after it rises, `sdo_oe` is low and any transfer in progress is abandoned. It is low after reset.
- R7: A written byte is stored only when all 8 of its bits have arrived. A partial byte left at chip select rise changes no entry.
- R8: A start address above 1055 is treated as 1055.
- R9: The two buffers are independent: writing one never changes the contents of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on the rising sck edge |
| sdo | output | 1 | Serial data out, updated after the falling sck edge |
| sdo_oe | output | 1 | Drive enable for sdo; low means high impedance |

## Verification
The hardest case to reach is a stream that crosses the fold from entry 1055 to entry 0 while it is still in progress. A second hard case is a chip select rise in the middle of a byte. The bench writes four bytes into both buffers starting at entry 1054, using different patterns, and reads each buffer back across the fold. An out-of-range start address puts the pointer at the last entry directly. The interrupted case sends one full byte and then five bits before chip select rises. A readback then shows that the entry after the full byte still holds its earlier value.

// File: rtl/dual_wrap_buf_port.sv
`timescale 1ns/1ps
module dual_wrap_buf_port #(
  parameter int BUF_BYTES = 1056
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int PW = $clog2(BUF_BYTES);
  localparam int HW = PW - 8;
  localparam logic [PW-1:0] LAST = PW'(BUF_BYTES - 1);

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_DUMMY, S_RD, S_WR, S_SKIP} st_t;

  logic [1:0] cs_p, sck_p, sdi_p;
  logic       sck_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p  <= 2'b11;
      sck_p <= 2'b00;
      sdi_p <= 2'b00;
      sck_q <= 1'b0;
    end else begin
      cs_p  <= {cs_p[0], cs_n};
      sck_p <= {sck_p[0], sck};
      sdi_p <= {sdi_p[0], sdi};
      sck_q <= sck_p[1];
    end

  wire cs_s     = cs_p[1];
  wire sdi_s    = sdi_p[1];
  wire sck_rise = sck_p[1] & ~sck_q;
  wire sck_fall = ~sck_p[1] & sck_q;

  st_t          st;
  logic         bsel, is_rd, ovld;
  logic [2:0]   bitcnt;
  logic [1:0]   abyte;
  logic [6:0]   sr;
  logic [HW-1:0] hi;
  logic [PW-1:0] ptr;
  logic [7:0]   obyte;

  logic [7:0] mem_a [BUF_BYTES];
  logic [7:0] mem_b [BUF_BYTES];

  wire [7:0]    byte_in   = {sr, sdi_s};
  wire          byte_done = ~cs_s & sck_rise & (bitcnt == 3'd7);
  wire [PW-1:0] addr_raw  = {hi, byte_in};
  wire [PW-1:0] addr_cl   = (addr_raw > LAST) ? LAST : addr_raw;
  wire [PW-1:0] ptr_inc   = (ptr == LAST) ? '0 : ptr + 1'b1;
  wire          wr_go     = byte_done & (st == S_WR);
  wire [7:0]    rd_byte   = bsel ? mem_b[ptr] : mem_a[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_CMD;
      bsel   <= 1'b0;
      is_rd  <= 1'b0;
      ovld   <= 1'b0;
      bitcnt <= '0;
      abyte  <= '0;
      sr     <= '0;
      hi     <= '0;
      ptr    <= '0;
      obyte  <= '0;
    end else if (cs_s) begin
      st     <= S_CMD;
      bitcnt <= '0;
      abyte  <= '0;
      ovld   <= 1'b0;
    end else begin
      if (sck_rise) begin
        sr     <= byte_in[6:0];
        bitcnt <= bitcnt + 1'b1;
      end
      if (byte_done)
        case (st)
          S_CMD: begin
            abyte <= '0;
            st    <= S_ADDR;
            case (byte_in)
              8'h54, 8'hD4: begin is_rd <= 1'b1; bsel <= 1'b0; end
              8'h56, 8'hD6: begin is_rd <= 1'b1; bsel <= 1'b1; end
              8'h84:        begin is_rd <= 1'b0; bsel <= 1'b0; end
              8'h87:        begin is_rd <= 1'b0; bsel <= 1'b1; end
              default:      st <= S_SKIP;
            endcase
          end
          S_ADDR: begin
            abyte <= abyte + 1'b1;
            if (abyte == 2'd1) hi <= byte_in[HW-1:0];
            if (abyte == 2'd2) begin
              ptr <= addr_cl;
              st  <= is_rd ? S_DUMMY : S_WR;
            end
          end
          S_DUMMY: st <= S_RD;
          S_WR:    ptr <= ptr_inc;
          default: ;
        endcase
      if (sck_fall && st == S_RD) begin
        if (bitcnt == 3'd0) begin
          obyte <= rd_byte;
          ptr   <= ptr_inc;
          ovld  <= 1'b1;
        end else begin
          obyte <= {obyte[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk)
    if (wr_go) begin
      if (bsel) mem_b[ptr] <= byte_in;
      else      mem_a[ptr] <= byte_in;
    end

  assign sdo_oe = (st == S_RD) & ovld;
  assign sdo    = sdo_oe & obyte[7];

  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);

  // R5
  ptr_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

  // R8
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);

  // R4
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(sck_fall));

  // R2
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP && !cs_s) |=> (st == S_SKIP && !sdo_oe));
endmodule

// File: tb/dual_wrap_buf_port_tb.sv
`timescale 1ns/1ps
module dual_wrap_buf_port_tb_top;
  localparam time HALF = 48ns;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] rbuf [8];

  always #4ns clk = ~clk;

  dual_wrap_buf_port dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
                            .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      #HALF;
      rx[i] = sdo;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic deselect();
    #HALF;
    cs_n = 1'b1;
    #(HALF * 2);
  endtask

  task automatic do_write(input logic [7:0] op, input logic [23:0] ad, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3, input int n);
    logic [7:0] dv [4];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    cs_n = 1'b0;
    #HALF;
    send(op); send(ad[23:16]); send(ad[15:8]); send(ad[7:0]);
    for (int i = 0; i < n; i++) send(dv[i]);
    deselect();
  endtask

  task automatic do_read(input logic [7:0] op, input logic [23:0] ad, input int n, input string req);
    logic [7:0] d;
    cs_n = 1'b0;
    #HALF;
    send(op); send(ad[23:16]); send(ad[15:8]); send(ad[7:0]);
    send(8'h00);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      rbuf[i] = d;
    end
    #(HALF / 2);
    chk(sdo_oe === 1'b1, {req, " oe during read"}, 16'(sdo_oe), 16'h1);
    deselect();
    chk(sdo_oe === 1'b0, "R6 oe after cs rise", 16'(sdo_oe), 16'h0);
  endtask

  task automatic t_reset();
    chk(sdo_oe === 1'b0, "R6 reset oe", 16'(sdo_oe), 16'h0);
  endtask

  task automatic t_basic();
    do_write(8'h84, 24'h000010, 8'hA1, 8'hB2, 8'hC3, 8'h00, 3);
    do_read(8'h54, 24'h000010, 3, "R1");
    chk(rbuf[0] === 8'hA1, "R4 first byte", 16'(rbuf[0]), 16'hA1);
    chk(rbuf[1] === 8'hB2, "R2 second byte", 16'(rbuf[1]), 16'hB2);
    chk(rbuf[2] === 8'hC3, "R1 third byte", 16'(rbuf[2]), 16'hC3);
  endtask

  task automatic t_wrap_both();
    do_write(8'h84, 24'h00041E, 8'h55, 8'h66, 8'h77, 8'h88, 4);
    do_write(8'h87, 24'h00041E, 8'h11, 8'h22, 8'h33, 8'h44, 4);
    do_read(8'h56, 24'h00041E, 4, "R5");
    chk(rbuf[0] === 8'h11, "R5 B entry 1054", 16'(rbuf[0]), 16'h11);
    chk(rbuf[1] === 8'h22, "R5 B entry 1055", 16'(rbuf[1]), 16'h22);
    chk(rbuf[2] === 8'h33, "R5 B entry 0", 16'(rbuf[2]), 16'h33);
    chk(rbuf[3] === 8'h44, "R5 B entry 1", 16'(rbuf[3]), 16'h44);
    do_read(8'hD4, 24'h00041E, 4, "R9");
    chk(rbuf[0] === 8'h55, "R9 A entry 1054", 16'(rbuf[0]), 16'h55);
    chk(rbuf[2] === 8'h77, "R9 A entry 0", 16'(rbuf[2]), 16'h77);
    chk(rbuf[3] === 8'h88, "R9 A entry 1", 16'(rbuf[3]), 16'h88);
  endtask

  task automatic t_ignored_bits();
    do_read(8'hD6, 24'hFFFC1E, 2, "R3");
    chk(rbuf[0] === 8'h11, "R3 high bits ignored", 16'(rbuf[0]), 16'h11);
    chk(rbuf[1] === 8'h22, "R3 next entry", 16'(rbuf[1]), 16'h22);
  endtask

  task automatic t_clamp();
    do_write(8'h84, 24'h0007FF, 8'h9A, 8'h9B, 8'h00, 8'h00, 2);
    do_read(8'h54, 24'h00041F, 2, "R8");
    chk(rbuf[0] === 8'h9A, "R8 clamped to 1055", 16'(rbuf[0]), 16'h9A);
    chk(rbuf[1] === 8'h9B, "R8 fold after clamp", 16'(rbuf[1]), 16'h9B);
  endtask

  task automatic t_partial();
    do_write(8'h84, 24'h000064, 8'hC0, 8'hC1, 8'h00, 8'h00, 2);
    cs_n = 1'b0;
    #HALF;
    send(8'h84); send(8'h00); send(8'h00); send(8'h64);
    send(8'h5A);
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b1; #HALF; sck = 1'b1; #HALF; sck = 1'b0;
    end
    deselect();
    do_read(8'h54, 24'h000064, 2, "R7");
    chk(rbuf[0] === 8'h5A, "R7 full byte stored", 16'(rbuf[0]), 16'h5A);
    chk(rbuf[1] === 8'hC1, "R7 partial byte dropped", 16'(rbuf[1]), 16'hC1);
  endtask

  task automatic t_bad_op();
    logic seen = 1'b0;
    cs_n = 1'b0;
    #HALF;
    send(8'h53); send(8'h00); send(8'h00); send(8'h10);
    send(8'hEE); send(8'hEF);
    seen = sdo_oe;
    deselect();
    chk(seen === 1'b0, "R2 bad opcode no output", 16'(seen), 16'h0);
    do_read(8'h54, 24'h000010, 2, "R2");
    chk(rbuf[0] === 8'hA1, "R2 bad opcode no write", 16'(rbuf[0]), 16'hA1);
    chk(rbuf[1] === 8'hB2, "R2 bad opcode no write 2", 16'(rbuf[1]), 16'hB2);
  endtask

  task automatic t_abort_read();
    logic [7:0] d;
    cs_n = 1'b0;
    #HALF;
    send(8'h56); send(8'h00); send(8'h04); send(8'h1E); send(8'h00);
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b0; #HALF; sck = 1'b1; #HALF; sck = 1'b0;
    end
    #(HALF / 2);
    chk(sdo_oe === 1'b1, "R6 oe mid byte", 16'(sdo_oe), 16'h1);
    deselect();
    chk(sdo_oe === 1'b0, "R6 oe after abort", 16'(sdo_oe), 16'h0);
    do_read(8'h56, 24'h00041E, 1, "R6");
    chk(rbuf[0] === 8'h11, "R6 restart after abort", 16'(rbuf[0]), 16'h11);
    d = 8'h00;
  endtask

  initial begin
    #1ns;
    #40ns;
    rst_n = 1'b1;
    #40ns;
    t_reset();
    t_basic();
    t_wrap_both();
    t_ignored_bits();
    t_clamp();
    t_partial();
    t_bad_op();
    t_abort_read();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule